// File: doc/BRIEF.md
# Protected Management-Memory Access Filter

This block sits between the request sources and the DRAM controller and guards one protected memory region reserved for the processor's system-management firmware. Each request carries its origin (processor or I/O link), an address, a direction, byte enables, a writeback marker, a code-or-data marker and a marker saying the address came out of graphics page-table translation. From these, the processor's management-mode status and four control bits, the block picks one of three routes: serve the request from the protected DRAM, forward it to the I/O or graphics path, or redirect it to a harmless fixed address.

The region is set by a base register and a size register. An address is inside when base <= address < base + size, and only while the global enable bit is set. Translated accesses that land in the region are never aborted. They are sent to the fixed address, and a sticky page-table error flag is raised.

Configuration uses a small write-only port. Every decision is registered and appears one clock after the request.

Top module: `mgmt_guard`

## Requirements
- R1: After a synchronous reset, out_valid, out_invalid and pgt_err are 0. Enable, lock, close, open, base and size are all 0.
- R2: While the enable bit (control bit 0) is 0, no request is routed to the protected DRAM (route code 0). Every request is forwarded (route code 1).
- R3: With enable set, an address hits only when base <= addr < base + size. A request that misses is forwarded, with its address and byte enables unchanged.
- R4: A non-translated request from the I/O link (req_from_io = 1) that hits the region is forwarded and never served from the protected DRAM.
- R5: A non-translated processor writeback (req_wb = 1) that hits the region goes to the protected DRAM, whatever the open bit and management mode are.
- R6: With close (control bit 2) set and the processor in management mode, a data access that hits is forwarded and a code fetch that hits goes to the protected DRAM. With close clear, both go to the protected DRAM in management mode.
- R7: Outside management mode, a code or data hit goes to the protected DRAM only if open (control bit 3) is effective. Otherwise it is forwarded.
- R8: A translated request (req_xlat = 1) that hits, from either origin, is redirected (route code 2) to address 0x000C0000. A write has its byte enables cleared. A read keeps its byte enables.
- R9: Every translated hit sets pgt_err. pgt_err stays set until a configuration write with select 3 and data bit 0 = 1 clears it. A hit in the same cycle as the clear wins.
- R10: Lock (control bit 1) can only be set, and stays set until reset. While it is set, open counts as 0 for decisions and writes to open are ignored.
- R11: In management mode, when close and effective open are both 1, a data hit is forwarded and out_invalid is 1 for that result. In every other case out_invalid is 0.
- R12: out_valid is req_valid delayed by exactly one clock. While no request is present, out_route, out_addr and out_be hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 control, 1 base, 2 size, 3 error clear |
| cfg_wdata | input | ADDR_W | Write data (control: bit0 enable, bit1 lock, bit2 close, bit3 open) |
| req_valid | input | 1 | Request present this cycle |
| req_from_io | input | 1 | 1 = I/O link origin, 0 = processor |
| req_addr | input | ADDR_W | Physical request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wb | input | 1 | Processor writeback |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| req_xlat | input | 1 | Address produced by graphics page-table translation |
| req_be | input | BE_W | Byte enables |
| cpu_mgmt_mode | input | 1 | Processor is in management mode |
| out_valid | output | 1 | Decision present |
| out_route | output | 2 | 0 protected DRAM, 1 forward, 2 redirect |
| out_addr | output | ADDR_W | Address to issue |
| out_be | output | BE_W | Byte enables to issue |
| out_invalid | output | 1 | Invalid close/open combination hit |
| pgt_err | output | 1 | Sticky page-table error flag |

## Verification
Requests are placed at base - 1, at base, at the last byte and at base + size. This separates an inclusive upper compare from an exclusive one and shows that misses pass through unchanged. The same hit is then sent under every combination of origin, translation, writeback, code or data, and management mode, against each setting of close and open. Each pairing separates one routing rule from the others: writeback against open, close on code against close on data, and I/O origin against processor. Lock is applied after open has been set, and open is rewritten while locked, to show that the open bit loses its effect. Error-flag clears are issued both alone and in the same cycle as a translated hit, to fix which one wins.

// File: rtl/mgmt_guard_pkg.sv
package mgmt_guard_pkg;
  typedef enum logic [1:0] {
    ROUTE_PROT  = 2'd0,
    ROUTE_FWD   = 2'd1,
    ROUTE_REDIR = 2'd2
  } route_e;

  typedef struct packed {
    logic open;
    logic close;
    logic lock;
    logic enable;
  } guard_ctl_t;

  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_SIZE = 2'd2;
  localparam logic [1:0] SEL_ERR  = 2'd3;
endpackage

// File: rtl/mgmt_guard_cfg.sv
module mgmt_guard_cfg
  import mgmt_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              err_set,
  output guard_ctl_t        ctl,
  output logic [ADDR_W-1:0] rgn_base,
  output logic [ADDR_W-1:0] rgn_size,
  output logic              pgt_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      rgn_base <= '0;
      rgn_size <= '0;
    end else if (cfg_wr) begin
      case (cfg_sel)
        SEL_CTL: begin
          ctl.enable <= cfg_wdata[0];
          ctl.lock   <= ctl.lock | cfg_wdata[1];
          ctl.close  <= cfg_wdata[2];
          if (!ctl.lock) ctl.open <= cfg_wdata[3];
        end
        SEL_BASE: rgn_base <= cfg_wdata;
        SEL_SIZE: rgn_size <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pgt_err <= 1'b0;
    else if (err_set)
      pgt_err <= 1'b1;
    else if (cfg_wr && cfg_sel == SEL_ERR && cfg_wdata[0])
      pgt_err <= 1'b0;
  end
endmodule

// File: rtl/mgmt_guard_region.sv
module mgmt_guard_region #(
  parameter int ADDR_W = 32
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  output logic              hit
);
  localparam int WIDE_W = ADDR_W + 1;
  logic [WIDE_W-1:0] limit;
  logic              above_base;
  logic              below_limit;

  always_comb begin
    limit       = {1'b0, base} + {1'b0, size};
    above_base  = addr >= base;
    below_limit = {1'b0, addr} < limit;
    hit         = enable && above_base && below_limit;
  end
endmodule

// File: rtl/mgmt_guard_policy.sv
module mgmt_guard_policy
  import mgmt_guard_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              BE_W       = 8,
  parameter logic [ADDR_W-1:0] REDIR_ADDR = 'h000C0000
) (
  input  logic              hit,
  input  logic              from_io,
  input  logic              xlat,
  input  logic              write,
  input  logic              wb,
  input  logic              code,
  input  logic              mgmt_mode,
  input  guard_ctl_t        ctl,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  output route_e            route,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_o,
  output logic              invalid,
  output logic              xlat_block
);
  logic open_eff;
  logic close_data;

  always_comb begin
    open_eff   = ctl.open && !ctl.lock;
    close_data = mgmt_mode && ctl.close && !code;
    route      = ROUTE_FWD;
    addr_o     = addr_i;
    be_o       = be_i;
    invalid    = 1'b0;
    xlat_block = 1'b0;
    if (hit) begin
      if (xlat) begin
        route      = ROUTE_REDIR;
        addr_o     = REDIR_ADDR;
        xlat_block = 1'b1;
        if (write) be_o = '0;
      end else if (from_io) begin
        route = ROUTE_FWD;
      end else if (wb) begin
        route = ROUTE_PROT;
      end else if (close_data) begin
        route   = ROUTE_FWD;
        invalid = open_eff;
      end else if (mgmt_mode || open_eff) begin
        route = ROUTE_PROT;
      end
    end
  end
endmodule

// File: rtl/mgmt_guard.sv
module mgmt_guard
  import mgmt_guard_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              BE_W       = 8,
  parameter logic [ADDR_W-1:0] REDIR_ADDR = 'h000C0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_from_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_wb,
  input  logic              req_code,
  input  logic              req_xlat,
  input  logic [BE_W-1:0]   req_be,
  input  logic              cpu_mgmt_mode,
  output logic              out_valid,
  output logic [1:0]        out_route,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BE_W-1:0]   out_be,
  output logic              out_invalid,
  output logic              pgt_err
);
  guard_ctl_t        ctl;
  logic [ADDR_W-1:0] rgn_base;
  logic [ADDR_W-1:0] rgn_size;
  logic              rgn_hit;
  route_e            nxt_route;
  logic [ADDR_W-1:0] nxt_addr;
  logic [BE_W-1:0]   nxt_be;
  logic              nxt_invalid;
  logic              nxt_block;
  logic              err_set;

  assign err_set = req_valid && nxt_block;

  mgmt_guard_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .err_set  (err_set),
    .ctl      (ctl),
    .rgn_base (rgn_base),
    .rgn_size (rgn_size),
    .pgt_err  (pgt_err)
  );

  mgmt_guard_region #(.ADDR_W(ADDR_W)) u_region (
    .enable(ctl.enable),
    .addr  (req_addr),
    .base  (rgn_base),
    .size  (rgn_size),
    .hit   (rgn_hit)
  );

  mgmt_guard_policy #(
    .ADDR_W    (ADDR_W),
    .BE_W      (BE_W),
    .REDIR_ADDR(REDIR_ADDR)
  ) u_policy (
    .hit       (rgn_hit),
    .from_io   (req_from_io),
    .xlat      (req_xlat),
    .write     (req_write),
    .wb        (req_wb),
    .code      (req_code),
    .mgmt_mode (cpu_mgmt_mode),
    .ctl       (ctl),
    .addr_i    (req_addr),
    .be_i      (req_be),
    .route     (nxt_route),
    .addr_o    (nxt_addr),
    .be_o      (nxt_be),
    .invalid   (nxt_invalid),
    .xlat_block(nxt_block)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_route   <= ROUTE_FWD;
      out_addr    <= '0;
      out_be      <= '0;
      out_invalid <= 1'b0;
    end else begin
      out_valid   <= req_valid;
      out_invalid <= req_valid && nxt_invalid;
      if (req_valid) begin
        out_route <= nxt_route;
        out_addr  <= nxt_addr;
        out_be    <= nxt_be;
      end
    end
  end
endmodule

// File: rtl/mgmt_guard_checker.sv
module mgmt_guard_checker #(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] REDIR_ADDR = 'h000C0000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_from_io,
  input logic              req_xlat,
  input logic              ctl_enable,
  input logic              ctl_lock,
  input logic              rgn_hit,
  input logic              out_valid,
  input logic [1:0]        out_route,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_invalid,
  input logic              pgt_err
);
  assert_no_prot_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ctl_enable) |=> (out_route != 2'd0));

  assert_io_never_prot_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_from_io && !req_xlat) |=> (out_route != 2'd0));

  assert_redir_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_route == 2'd2) |-> (out_addr == REDIR_ADDR));

  assert_xlat_hit_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_xlat && rgn_hit) |=> pgt_err);

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ctl_lock |=> ctl_lock);

  assert_invalid_forwards_R11: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> (out_valid && out_route == 2'd1));

  assert_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
endmodule

bind mgmt_guard mgmt_guard_checker #(
  .ADDR_W    (ADDR_W),
  .REDIR_ADDR(REDIR_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_from_io(req_from_io),
  .req_xlat   (req_xlat),
  .ctl_enable (ctl.enable),
  .ctl_lock   (ctl.lock),
  .rgn_hit    (rgn_hit),
  .out_valid  (out_valid),
  .out_route  (out_route),
  .out_addr   (out_addr),
  .out_invalid(out_invalid),
  .pgt_err    (pgt_err)
);

// File: tb/mgmt_guard_bench.sv
`timescale 1ns/1ps
module mgmt_guard_bench;
  localparam int AW = 32;
  localparam int BW = 8;
  localparam logic [AW-1:0] RADDR = 32'h000C0000;
  localparam logic [AW-1:0] BASE  = 32'h00030000;
  localparam logic [AW-1:0] SIZE  = 32'h00001000;

  logic clk = 1'b0;
  logic rst;
  logic cfg_wr;
  logic [1:0] cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic req_valid, req_from_io, req_write, req_wb, req_code, req_xlat, cpu_mgmt_mode;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] req_be;
  logic out_valid, out_invalid, pgt_err;
  logic [1:0] out_route;
  logic [AW-1:0] out_addr;
  logic [BW-1:0] out_be;

  always #2 clk = ~clk;

  mgmt_guard #(.ADDR_W(AW), .BE_W(BW), .REDIR_ADDR(RADDR)) u_mgmt_guard (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_from_io(req_from_io), .req_addr(req_addr),
    .req_write(req_write), .req_wb(req_wb), .req_code(req_code), .req_xlat(req_xlat),
    .req_be(req_be), .cpu_mgmt_mode(cpu_mgmt_mode), .out_valid(out_valid),
    .out_route(out_route), .out_addr(out_addr), .out_be(out_be),
    .out_invalid(out_invalid), .pgt_err(pgt_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit m_en, m_lock, m_close, m_open, m_err;
  longint m_base, m_size;
  bit e_valid, e_invalid;
  int e_route;
  longint e_addr;
  int e_be;

  task automatic model_reset();
    m_en = 0; m_lock = 0; m_close = 0; m_open = 0; m_err = 0;
    m_base = 0; m_size = 0;
    e_valid = 0; e_invalid = 0; e_route = 1; e_addr = 0; e_be = 0;
  endtask

  task automatic compare(string tag);
    bit bad;
    bad = 0;
    checks++;
    if (out_valid !== e_valid) begin
      $display("FAIL %s out_valid actual %0d expected %0d", tag, out_valid, e_valid); bad = 1;
    end
    if (out_invalid !== e_invalid) begin
      $display("FAIL %s out_invalid actual %0d expected %0d", tag, out_invalid, e_invalid); bad = 1;
    end
    if (pgt_err !== m_err) begin
      $display("FAIL %s pgt_err actual %0d expected %0d", tag, pgt_err, m_err); bad = 1;
    end
    if (out_route !== 2'(e_route)) begin
      $display("FAIL %s out_route actual %0d expected %0d", tag, out_route, e_route); bad = 1;
    end
    if (out_addr !== AW'(e_addr)) begin
      $display("FAIL %s out_addr actual %h expected %h", tag, out_addr, AW'(e_addr)); bad = 1;
    end
    if (out_be !== BW'(e_be)) begin
      $display("FAIL %s out_be actual %h expected %h", tag, out_be, BW'(e_be)); bad = 1;
    end
    if (bad) fails++;
  endtask

  // predicts one clock edge from the driven inputs, then checks after it
  task automatic step(string tag);
    bit hit, oe, set_err;
    longint a;
    set_err = 0;
    a   = longint'(req_addr);
    oe  = m_open && !m_lock;
    hit = m_en && a >= m_base && a < m_base + m_size;
    e_valid   = req_valid;
    e_invalid = 0;
    if (req_valid) begin
      e_addr = a; e_be = int'(req_be); e_route = 1;
      if (hit) begin
        if (req_xlat) begin
          e_route = 2; e_addr = longint'(RADDR); set_err = 1;
          if (req_write) e_be = 0;
        end else if (req_from_io) e_route = 1;
        else if (req_wb) e_route = 0;
        else if (cpu_mgmt_mode && m_close && !req_code) begin
          e_route = 1; e_invalid = oe;
        end else if (cpu_mgmt_mode || oe) e_route = 0;
      end
    end
    if (cfg_wr) begin
      case (cfg_sel)
        2'd0: begin
          m_en = cfg_wdata[0]; m_close = cfg_wdata[2];
          if (!m_lock) m_open = cfg_wdata[3];
          m_lock = m_lock | cfg_wdata[1];
        end
        2'd1: m_base = longint'(cfg_wdata);
        2'd2: m_size = longint'(cfg_wdata);
        default: if (cfg_wdata[0]) m_err = 0;
      endcase
    end
    if (set_err) m_err = 1;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle_inputs();
    cfg_wr = 0; cfg_sel = 0; cfg_wdata = '0;
    req_valid = 0; req_from_io = 0; req_addr = '0; req_write = 0;
    req_wb = 0; req_code = 0; req_xlat = 0; req_be = '0; cpu_mgmt_mode = 0;
  endtask

  task automatic cfg(logic [1:0] sel, logic [AW-1:0] d, string tag);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    step(tag);
    cfg_wr = 0;
  endtask

  // control word: {open, close, lock, enable}
  task automatic ctlw(bit op, bit cl, bit lk, bit en, string tag);
    cfg(2'd0, AW'({op, cl, lk, en}), tag);
  endtask

  task automatic req(bit io, logic [AW-1:0] addr, bit wr, bit wb, bit code,
                     bit xl, bit mm, logic [BW-1:0] be, string tag);
    req_valid = 1; req_from_io = io; req_addr = addr; req_write = wr; req_wb = wb;
    req_code = code; req_xlat = xl; cpu_mgmt_mode = mm; req_be = be;
    step(tag);
    req_valid = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired actual running expected finished");
      fails++;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare("R1 reset state");
    step("R1 idle after reset");
    // R1/R2: base and size programmed, controls still zero after reset
    cfg(2'd1, BASE, "R1 base write");
    cfg(2'd2, SIZE, "R1 size write");
    req(0, BASE, 0, 0, 0, 0, 1, 8'hFF, "R2 enable off mgmt data");
    req(0, BASE + 4, 1, 1, 0, 0, 1, 8'h0F, "R2 enable off writeback");
    ctlw(0, 0, 0, 1, "R3 enable on");
    // R3 boundaries
    req(0, BASE - 1, 0, 0, 0, 0, 1, 8'h01, "R3 below base");
    req(0, BASE, 0, 0, 0, 0, 1, 8'h02, "R3 at base");
    req(0, BASE + SIZE - 1, 0, 0, 0, 0, 1, 8'h04, "R3 last byte");
    req(0, BASE + SIZE, 1, 0, 0, 0, 1, 8'h08, "R3 at limit");
    // R12 hold
    step("R12 idle holds outputs");
    // R7 closed, outside mgmt mode
    req(0, BASE + 16, 0, 0, 0, 0, 0, 8'hFF, "R7 non-mgmt data closed");
    req(0, BASE + 16, 0, 0, 1, 0, 0, 8'hFF, "R7 non-mgmt code closed");
    // R4
    req(1, BASE + 32, 1, 0, 0, 0, 1, 8'h3C, "R4 io direct write");
    req(1, BASE + 32, 0, 0, 1, 0, 1, 8'h3C, "R4 io direct read");
    // R5
    req(0, BASE + 64, 1, 1, 0, 0, 0, 8'hF0, "R5 writeback non-mgmt");
    // R6
    ctlw(0, 1, 0, 1, "R6 close on");
    req(0, BASE + 8, 0, 0, 0, 0, 1, 8'hFF, "R6 close mgmt data");
    req(0, BASE + 8, 0, 0, 1, 0, 1, 8'hFF, "R6 close mgmt code");
    req(0, BASE + 8, 1, 1, 0, 0, 1, 8'hFF, "R5 writeback under close");
    // R7 open
    ctlw(1, 0, 0, 1, "R7 open on");
    req(0, BASE + 8, 0, 0, 0, 0, 0, 8'hAA, "R7 open non-mgmt data");
    req(0, BASE + 8, 0, 0, 1, 0, 0, 8'hAA, "R7 open non-mgmt code");
    // R11
    ctlw(1, 1, 0, 1, "R11 open and close");
    req(0, BASE + 8, 0, 0, 0, 0, 1, 8'h55, "R11 invalid mgmt data");
    req(0, BASE + 8, 0, 0, 1, 0, 1, 8'h55, "R11 mgmt code not invalid");
    req(0, BASE + 8, 0, 0, 0, 0, 0, 8'h55, "R11 non-mgmt data not invalid");
    // R8 / R9
    req(0, BASE + 12, 0, 0, 0, 1, 1, 8'hC3, "R8 xlat read keeps be");
    req(1, BASE + 12, 1, 0, 0, 1, 0, 8'hC3, "R8 io aperture write cleared be");
    cfg(2'd3, 32'h0, "R9 clear with bit0 zero ignored");
    cfg(2'd3, 32'h1, "R9 clear");
    req(0, BASE - 4, 1, 0, 0, 1, 1, 8'h11, "R9 xlat miss no flag");
    // clear and hit in the same cycle
    req_valid = 1; req_from_io = 0; req_addr = BASE; req_write = 1; req_wb = 0;
    req_code = 0; req_xlat = 1; cpu_mgmt_mode = 0; req_be = 8'hFF;
    cfg_wr = 1; cfg_sel = 2'd3; cfg_wdata = 32'h1;
    step("R9 hit beats clear");
    req_valid = 0; cfg_wr = 0;
    cfg(2'd3, 32'h1, "R9 clear again");
    // R10 lock
    ctlw(1, 0, 1, 1, "R10 lock set");
    req(0, BASE + 8, 0, 0, 0, 0, 0, 8'h77, "R10 open ignored under lock");
    ctlw(1, 1, 0, 1, "R10 lock clear attempt");
    req(0, BASE + 8, 0, 0, 1, 0, 0, 8'h77, "R10 code denied under lock");
    req(0, BASE + 8, 0, 0, 0, 0, 1, 8'h77, "R10 no invalid under lock");
    ctlw(0, 0, 0, 1, "R10 open write while locked");
    ctlw(1, 0, 0, 1, "R10 reopen attempt");
    req(0, BASE + 8, 0, 0, 0, 0, 0, 8'h77, "R10 still denied");
    ctlw(1, 0, 0, 0, "R2 disable while locked");
    req(0, BASE + 8, 0, 0, 0, 0, 1, 8'h99, "R2 disabled mgmt data");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule